// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access. It first tries three shortcuts that need no memory traffic. A physical-mode request passes straight through. An address that is not properly sign-extended is refused. A kernel access to the direct-mapped superpage region is relocated in place. Any other request walks a three-level table in memory, one 8-byte entry per level, through a simple request/response read port.

At the end of each translation the block pulses `done_o` for one cycle. With it come the physical address, the granted permissions and a fault code. Only one translation is in flight at a time: a new request is taken only while the walker is idle. The leaf entry decides the permissions. Its fault-on-access bits can then take a permission away again, and that produces a fault-on-read, fault-on-write or fault-on-execute code.

Pages are 8 KiB (13 offset bits). Each level uses 10 index bits, so 43 bits of virtual address take part in a walk.

Top module: `pt_walker`

## Requirements
- R1: When `req_mode_i` is 2 or 3 (physical), the result is `paddr_o` = `req_vaddr_i`, `perm_o` = 3'b111 and fault 0 (none). No memory read is issued, and `done_o` is high in the cycle after the request is accepted.
- R2: Outside physical mode, if virtual address bits 63:43 are not all equal, the result is fault 1 (access violation) with `paddr_o` = 0 and `perm_o` = 0. No read is issued and `done_o` follows one cycle after acceptance.
- R3: A sign-correct address with bit 63 set and bits 42:41 = 2'b10 is a superpage access. In kernel mode (0) the result is `paddr_o` = {bit 40 placed at bit 43, bits 39:0}, all other bits zero, with `perm_o` = 3'b111 and fault 0. In user mode (1) the result is fault 1.
- R4: Any other address takes up to three reads, highest level first. The first read is at `ptbr_i` + 8·VA[42:33]. Each later read is at (previous entry[63:32] << 13) + 8·index, using VA[32:23] for the second level and VA[22:13] for the third.
- R5: `mem_req_valid_o` stays high with a stable `mem_req_addr_o` until `mem_req_ready_i` is seen. The next read is issued only after `mem_rsp_valid_i` has returned the previous entry.
- R6: An entry with bit 0 (valid) clear at any level ends the walk with fault 2 (translation not valid), `paddr_o` = 0 and `perm_o` = 0.
- R7: A valid first- or second-level entry with bit 8 (kernel read enable) clear ends the walk with fault 1, `paddr_o` = 0 and `perm_o` = 0, whatever the mode.
- R8: The leaf read-enable bit is bit 8 + mode and the write-enable bit is bit 12 + mode. Read enable grants read and execute. Permission bits are bit 0 read, bit 1 write, bit 2 execute. If the need mask is nonzero and overlaps none of the granted bits, the result is fault 1, with `perm_o` equal to the granted bits.
- R9: Leaf bits 1, 2 and 3 remove read, write and execute respectively. If the remaining bits do not overlap the need mask, the fault is 5 (execute) if execute is needed, else 4 (write) if write is needed, else 3 (read). A zero need mask gives fault 0.
- R10: For a leaf without an invalid-entry fault, `paddr_o` = (leaf[63:32] << 13) | VA[12:0] and `perm_o` = the permissions left after R9.
- R11: `done_o` is a one-cycle pulse per accepted request. Requests that arrive while a translation is in progress are ignored. After reset `done_o` and `mem_req_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a translation (taken when idle) |
| req_vaddr_i | input | 64 | Virtual address |
| req_need_i | input | 3 | Needed access: bit0 read, bit1 write, bit2 execute |
| req_mode_i | input | 2 | 0 kernel, 1 user, 2/3 physical |
| ptbr_i | input | 64 | Base address of the first-level table |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 64 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 64 | Entry data |
| done_o | output | 1 | Result valid for one cycle |
| paddr_o | output | 64 | Physical address |
| perm_o | output | 3 | Granted permissions |
| fault_o | output | 3 | 0 none, 1 access violation, 2 not valid, 3/4/5 fault on read/write/execute |

## Verification
The assertions check the following on every cycle:
- `done_o` is a single-cycle pulse.
- An unanswered read request holds its address.
- A physical-mode translation never touches memory.
- A user-mode superpage access always faults.
- A successful result grants some needed bit, and a fault-on-access result grants none.

Only the bench scenarios can show the rest: the exact entry addresses at each level, the superpage bit relocation, the fault priority among the three fault-on bits, and the mode-dependent enable bits. These are shown by walking hand-built tables under varying memory stalls and comparing against a behavioural model.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  localparam logic [1:0] MODE_KERN = 2'd0;
  localparam logic [1:0] MODE_USER = 2'd1;

  localparam int PTE_V   = 0;
  localparam int PTE_FO  = 1;   // fault-on bits [3:1] = X,W,R
  localparam int PTE_KRE = 8;
  localparam int PTE_KWE = 12;

  typedef struct packed {
    logic [63:0] paddr;
    logic [2:0]  perm;
    fault_e      fault;
  } result_t;
endpackage

// File: rtl/pt_walker_precheck.sv
module pt_walker_precheck
  import pt_walker_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int IMPL_BITS = 43
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      mode_i,
  output logic            imm_o,
  output result_t         res_o
);
  localparam int SP_HI  = IMPL_BITS - 1;
  localparam int SP_LO  = IMPL_BITS - 2;
  localparam int RL_SRC = IMPL_BITS - 3;
  localparam int RL_DST = IMPL_BITS;

  logic [VA_W-IMPL_BITS-1:0] hi;
  logic sign_ok, superpage;
  logic [63:0] sp_pa;

  assign hi        = va_i[VA_W-1:IMPL_BITS];
  assign sign_ok   = (&hi) | ~(|hi);
  assign superpage = va_i[VA_W-1] && (va_i[SP_HI:SP_LO] == 2'b10);

  always_comb begin
    sp_pa         = 64'(va_i[RL_SRC-1:0]);
    sp_pa[RL_DST] = va_i[RL_SRC];
  end

  always_comb begin
    imm_o = 1'b1;
    res_o = '0;
    if (mode_i[1]) begin
      res_o.paddr = 64'(va_i);
      res_o.perm  = 3'b111;
    end else if (!sign_ok) begin
      res_o.fault = FLT_ACV;
    end else if (superpage) begin
      if (mode_i == MODE_KERN) begin
        res_o.paddr = sp_pa;
        res_o.perm  = 3'b111;
      end else begin
        res_o.fault = FLT_ACV;
      end
    end else begin
      imm_o = 1'b0;
    end
  end
endmodule

// File: rtl/pt_walker_leaf.sv
module pt_walker_leaf
  import pt_walker_pkg::*;
#(
  parameter int PAGE_BITS = 13
) (
  input  logic [63:0]          pte_i,
  input  logic [PAGE_BITS-1:0] offs_i,
  input  logic                 user_i,
  input  logic [2:0]           need_i,
  output result_t              res_o
);
  logic rd_en, wr_en;
  logic [2:0] granted, remain;
  logic unused_pte;

  assign rd_en   = pte_i[PTE_KRE + int'(user_i)];
  assign wr_en   = pte_i[PTE_KWE + int'(user_i)];
  assign granted = {rd_en, wr_en, rd_en};
  assign remain  = granted & ~pte_i[PTE_FO +: 3];
  assign unused_pte = ^{pte_i[31:14], pte_i[11:10], pte_i[7:4]};

  always_comb begin
    res_o = '0;
    if (!pte_i[PTE_V]) begin
      res_o.fault = FLT_TNV;
    end else begin
      res_o.paddr = ({32'b0, pte_i[63:32]} << PAGE_BITS) | 64'(offs_i);
      if ((need_i != 3'b0) && ((granted & need_i) == 3'b0)) begin
        res_o.perm  = granted;
        res_o.fault = FLT_ACV;
      end else begin
        res_o.perm = remain;
        if ((remain & need_i) == 3'b0) begin
          if (need_i[2])      res_o.fault = FLT_FOE;
          else if (need_i[1]) res_o.fault = FLT_FOW;
          else if (need_i[0]) res_o.fault = FLT_FOR;
        end
      end
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [63:0] req_vaddr_i,
  input  logic [2:0]  req_need_i,
  input  logic [1:0]  req_mode_i,
  input  logic [63:0] ptbr_i,
  output logic        mem_req_valid_o,
  input  logic        mem_req_ready_i,
  output logic [63:0] mem_req_addr_o,
  input  logic        mem_rsp_valid_i,
  input  logic [63:0] mem_rsp_data_i,
  output logic        done_o,
  output logic [63:0] paddr_o,
  output logic [2:0]  perm_o,
  output logic [2:0]  fault_o
);
  localparam int IMPL_BITS = PAGE_BITS + IDX_BITS * LEVELS;
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_SH    = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} state_e;

  state_e               state_q;
  logic [IMPL_BITS-1:0] va_q;
  logic [2:0]           need_q;
  logic                 user_q;
  logic [63:0]          base_q;
  logic [LVL_W-1:0]     lvl_q;
  result_t              res_q;

  logic    pre_imm;
  result_t pre_res, leaf_res;
  logic [IDX_BITS-1:0] idx_arr [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx_arr[g] = va_q[PAGE_BITS + IDX_BITS*(LEVELS-1-g) +: IDX_BITS];
  end

  pt_walker_precheck #(.VA_W(VA_W), .IMPL_BITS(IMPL_BITS)) u_pre (
    .va_i   (req_vaddr_i),
    .mode_i (req_mode_i),
    .imm_o  (pre_imm),
    .res_o  (pre_res)
  );

  pt_walker_leaf #(.PAGE_BITS(PAGE_BITS)) u_leaf (
    .pte_i  (mem_rsp_data_i),
    .offs_i (va_q[PAGE_BITS-1:0]),
    .user_i (user_q),
    .need_i (need_q),
    .res_o  (leaf_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      va_q    <= '0;
      need_q  <= '0;
      user_q  <= 1'b0;
      base_q  <= '0;
      lvl_q   <= '0;
      res_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          va_q   <= req_vaddr_i[IMPL_BITS-1:0];
          need_q <= req_need_i;
          user_q <= req_mode_i[0];
          base_q <= ptbr_i;
          lvl_q  <= '0;
          if (pre_imm) begin
            res_q   <= pre_res;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_REQ;
          end
        end
        ST_REQ: if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (lvl_q == LVL_W'(LEVELS-1)) begin
            res_q   <= leaf_res;
            state_q <= ST_DONE;
          end else if (!mem_rsp_data_i[PTE_V]) begin
            res_q       <= '0;
            res_q.fault <= FLT_TNV;
            state_q     <= ST_DONE;
          end else if (!mem_rsp_data_i[PTE_KRE]) begin
            res_q       <= '0;
            res_q.fault <= FLT_ACV;
            state_q     <= ST_DONE;
          end else begin
            base_q  <= {32'b0, mem_rsp_data_i[63:32]} << PAGE_BITS;
            lvl_q   <= lvl_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = base_q + (64'(idx_arr[lvl_q]) << ENT_SH);
  assign done_o          = (state_q == ST_DONE);
  assign paddr_o         = res_q.paddr;
  assign perm_o          = res_q.perm;
  assign fault_o         = res_q.fault;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [63:0] req_vaddr_i,
  input logic [2:0]  req_need_i,
  input logic [1:0]  req_mode_i,
  input logic        mem_req_valid_o,
  input logic        mem_req_ready_i,
  input logic [63:0] mem_req_addr_o,
  input logic        done_o,
  input logic [2:0]  perm_o,
  input logic [2:0]  fault_o
);
  logic        busy;
  logic [2:0]  need_c;
  logic [1:0]  mode_c;
  logic        sp_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy <= 1'b0; need_c <= '0; mode_c <= '0; sp_c <= 1'b0;
    end else if (!busy && req_valid_i) begin
      busy   <= 1'b1;
      need_c <= req_need_i;
      mode_c <= req_mode_i;
      sp_c   <= (&req_vaddr_i[63:43]) && (req_vaddr_i[42:41] == 2'b10);
    end else if (done_o) begin
      busy <= 1'b0;
    end
  end

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!done_o && !mem_req_valid_o));
  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
  assert_phys_no_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && mode_c[1]) |-> !mem_req_valid_o);
  assert_user_superpage_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && sp_c && mode_c == 2'd1) |-> (fault_o == 3'd1));
  assert_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 3'd0 && need_c != 3'd0) |-> ((perm_o & need_c) != 3'd0));
  assert_fault_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o >= 3'd3) |-> ((perm_o & need_c) == 3'd0));
endmodule

bind pt_walker pt_walker_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_vaddr_i     (req_vaddr_i),
  .req_need_i      (req_need_i),
  .req_mode_i      (req_mode_i),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .done_o          (done_o),
  .perm_o          (perm_o),
  .fault_o         (fault_o)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [2:0]  req_need = '0;
  logic [1:0]  req_mode = '0;
  logic [63:0] ptbr = 64'h0000_0000_0020_0000;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done;
  logic [63:0] paddr;
  logic [2:0]  perm, fault;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_vaddr),
    .req_need_i(req_need), .req_mode_i(req_mode), .ptbr_i(ptbr),
    .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i(mem_rsp_data), .done_o(done), .paddr_o(paddr),
    .perm_o(perm), .fault_o(fault)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_q [$];
  logic [63:0] obs_q [$];
  bit in_txn = 1'b0;
  int nreq = 0, stall = 0, pend = 0;
  logic [63:0] pend_addr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // Behavioural reference: fills exp_q with the expected read addresses
  function automatic void model(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                                output logic [63:0] pa, output logic [2:0] pm, output logic [2:0] f);
    logic [63:0] base, pte, a;
    logic [20:0] hi;
    logic rde, wre;
    logic [2:0] g, r;
    exp_q.delete();
    pa = 0; pm = 0; f = 0;
    if (mode >= 2) begin pa = va; pm = 3'b111; return; end
    hi = va[63:43];
    if (hi != 21'h0 && hi != 21'h1fffff) begin f = 1; return; end
    if (va[63] && va[42:41] == 2'b10) begin
      if (mode == 0) begin
        pa = {20'h0, va[40], 3'b000, va[39:0]};
        pm = 3'b111;
      end else f = 1;
      return;
    end
    base = ptbr;
    for (int lvl = 0; lvl < 3; lvl++) begin
      int sh = 13 + 10 * (2 - lvl);
      a = base + (((va >> sh) & 64'h3ff) * 8);
      exp_q.push_back(a);
      pte = rd(a);
      if (!pte[0]) begin f = 2; return; end
      if (lvl < 2) begin
        if (!pte[8]) begin f = 1; return; end
        base = (pte >> 32) << 13;
      end else begin
        rde = pte[8 + mode];
        wre = pte[12 + mode];
        g = {rde, wre, rde};
        pa = ((pte >> 32) << 13) | (va & 64'h1fff);
        if (need != 0 && (g & need) == 0) begin pm = g; f = 1; return; end
        r = g & ~pte[3:1];
        pm = r;
        if ((r & need) == 0) f = need[2] ? 3'd5 : need[1] ? 3'd4 : need[0] ? 3'd3 : 3'd0;
      end
    end
  endfunction

  task automatic map(input logic [63:0] va, input logic [63:0] l2, input logic [63:0] l3,
                     input logic [31:0] frame, input logic [31:0] l1lo, input logic [31:0] l2lo,
                     input logic [31:0] leaflo);
    mem[ptbr + 64'(va[42:33]) * 8] = {32'(l2 >> 13), l1lo};
    mem[l2 + 64'(va[32:23]) * 8]   = {32'(l3 >> 13), l2lo};
    mem[l3 + 64'(va[22:13]) * 8]   = {frame, leaflo};
  endtask

  // Memory responder and per-clock idle check
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); end
    end
    mem_req_ready = 1'b0;
    if (mem_req_valid) begin
      if (stall > 0) stall--;
      else begin
        mem_req_ready = 1'b1;
        obs_q.push_back(mem_req_addr);
        pend_addr = mem_req_addr;
        pend = 1 + (nreq % 2);
        nreq++;
        stall = nreq % 3;
      end
    end
    if (!in_txn && rst_n) chk(!done && !mem_req_valid, "R11 idle outputs quiet", {62'h0, done, mem_req_valid}, 64'h0);
  end

  task automatic run(input logic [63:0] va, input logic [2:0] need, input logic [1:0] mode,
                     input string tag, input bit poke);
    logic [63:0] epa; logic [2:0] epm, ef;
    int cyc;
    model(va, need, mode, epa, epm, ef);
    obs_q.delete();
    in_txn = 1'b1;
    req_vaddr = va; req_need = need; req_mode = mode; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_vaddr = 64'h0; req_mode = 2'd2; req_need = 3'd0; req_valid = 1'b1;  // R11: must be ignored
    end
    cyc = 1;
    while (!done && cyc < 500) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
    end
    req_valid = 1'b0;
    if (exp_q.size() == 0)
      chk(cyc == 1, {tag, " done one cycle after accept"}, 64'(cyc), 64'd1);
    chk(done, {tag, " done seen"}, {63'h0, done}, 64'd1);
    chk(paddr == epa, {tag, " paddr"}, paddr, epa);
    chk(perm == epm, {tag, " perm"}, 64'(perm), 64'(epm));
    chk(fault == ef, {tag, " fault"}, 64'(fault), 64'(ef));
    chk(obs_q.size() == exp_q.size(), {tag, " R4 read count"}, 64'(obs_q.size()), 64'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
      chk(obs_q[i] == exp_q[i], {tag, " R4 entry address"}, obs_q[i], exp_q[i]);
    @(negedge clk);
    chk(!done, {tag, " R11 done single pulse"}, {63'h0, done}, 64'd0);
    in_txn = 1'b0;
  endtask

  localparam logic [63:0] VA_A = 64'h0000_0012_3456_7abc;
  localparam logic [63:0] VA_B = 64'h0000_0200_0040_2008;
  localparam logic [63:0] VA_C = 64'h0000_0300_0000_0000;
  localparam logic [63:0] VA_D = 64'h0000_0400_0080_0000;
  localparam logic [63:0] VA_E = 64'h0000_0500_0080_4000;
  localparam logic [63:0] VA_F = 64'h0000_0600_00c0_6010;
  localparam logic [63:0] VA_G = 64'h0000_0700_0100_8020;
  localparam logic [63:0] VA_H = 64'h0000_00a0_0140_a030;
  localparam logic [63:0] VA_K = 64'h0000_00c0_0180_c040;

  initial begin
    map(VA_A, 64'h10_0000, 64'h10_4000, 32'h0001_2345, 32'h101, 32'h101, 32'h1101);
    map(VA_B, 64'h20_0000, 64'h20_4000, 32'h0002_0001, 32'h101, 32'h101, 32'h2201);
    map(VA_D, 64'h30_0000, 64'h30_4000, 32'h0003_0000, 32'h001, 32'h101, 32'h1101);
    map(VA_E, 64'h40_0000, 64'h40_4000, 32'h0004_0000, 32'h101, 32'h001, 32'h1101);
    map(VA_F, 64'h50_0000, 64'h50_4000, 32'h0005_0000, 32'h101, 32'h101, 32'h1100);
    map(VA_G, 64'h60_0000, 64'h60_4000, 32'h0006_0007, 32'h101, 32'h101, 32'h110f);
    map(VA_H, 64'h70_0000, 64'h70_4000, 32'h0007_0003, 32'h101, 32'h101, 32'h1105);
    map(VA_K, 64'h80_0000, 64'h80_4000, 32'h0008_0009, 32'h101, 32'h101, 32'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !mem_req_valid, "R11 reset state", {62'h0, done, mem_req_valid}, 64'h0);

    run(64'hdead_beef_0123_4567, 3'b010, 2'd2, "R1 physical mode", 1'b0);
    run(64'h0000_1000_0000_0000, 3'b001, 2'd3, "R1 physical mode 3", 1'b0);
    run(64'h0000_1000_0000_0000, 3'b001, 2'd0, "R2 bad sign extension", 1'b0);
    run(64'h8000_0000_0000_0000, 3'b001, 2'd1, "R2 negative bad sign", 1'b0);
    run(64'hffff_fd00_1234_5678, 3'b100, 2'd0, "R3 superpage kernel", 1'b0);
    run(64'hffff_fc00_0000_0010, 3'b001, 2'd0, "R3 superpage kernel bit40 clear", 1'b0);
    run(64'hffff_fd00_1234_5678, 3'b001, 2'd1, "R3 superpage user", 1'b0);
    run(VA_A, 3'b001, 2'd0, "R4 R10 kernel read walk", 1'b0);
    run(VA_A, 3'b010, 2'd0, "R5 R10 kernel write walk", 1'b0);
    run(VA_C, 3'b001, 2'd0, "R6 first level not valid", 1'b0);
    run(64'hffff_f900_0000_0000, 3'b001, 2'd0, "R6 negative walk not valid", 1'b0);
    run(VA_F, 3'b001, 2'd0, "R6 leaf not valid", 1'b0);
    run(VA_D, 3'b001, 2'd1, "R7 first level no kernel read", 1'b0);
    run(VA_E, 3'b001, 2'd0, "R7 second level no kernel read", 1'b0);
    run(VA_B, 3'b011, 2'd1, "R8 user enables", 1'b0);
    run(VA_B, 3'b001, 2'd0, "R8 kernel bit clear", 1'b0);
    run(VA_A, 3'b010, 2'd1, "R8 user without user bits", 1'b0);
    run(VA_K, 3'b010, 2'd0, "R8 read-only page write", 1'b0);
    run(VA_G, 3'b100, 2'd0, "R9 fault on execute", 1'b0);
    run(VA_G, 3'b111, 2'd0, "R9 execute priority", 1'b0);
    run(VA_G, 3'b011, 2'd0, "R9 write over read", 1'b0);
    run(VA_G, 3'b001, 2'd0, "R9 fault on read", 1'b0);
    run(VA_G, 3'b000, 2'd0, "R9 zero need", 1'b0);
    run(VA_H, 3'b010, 2'd0, "R9 fault on write", 1'b0);
    run(VA_H, 3'b101, 2'd0, "R9 R10 partial removal", 1'b0);
    run(VA_A, 3'b100, 2'd0, "R11 request while busy", 1'b1);
    run(VA_H, 3'b001, 2'd0, "R11 after ignored request", 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule